// File: doc/BRIEF.md
# Write-Back Cache Control Sequencer

This block is the control state machine of a set-associative write-back data cache. Each cycle it looks at the CPU request, the pipeline stall, and the hit and dirty results of the tag lookup. From these it decides whether the access completes at once, or whether the cache must stall while a line is brought in and a dirty victim is pushed out. Two commands act on the whole cache. A flush walks every line and writes back the dirty ones. An invalidate clears every valid bit in one cycle.

The tag and data arrays, the replacement policy and the bus engine sit outside the block and are driven by its control outputs. On a miss with a dirty victim, the controller requests the demand line first and the victim writeback second. The fetched line reaches the data array only after the writeback is acknowledged. An uncacheable request bypasses the arrays and becomes a single-word bus access. A late pipeline flush cancels array writes and bus sequencing but leaves the same-cycle outputs alone.

Top module: `wbc_fsm`

## Requirements
- R1: After a synchronous active-low reset, with no request or command present:
  - the controller is idle;
  - `cache_stall` and every bus request are low;
  - `array_en` is high;
  - `flush_set` and `flush_way` are zero.
- R2: A cacheable request that hits while idle does not stall. A write hit with `pipe_stall` low asserts `cpu_wr_en` and `tag_set_dirty` in the same cycle. The request codes for `req_op` are: 1 = read, 2 = write, 0 or 3 = no request.
- R3: `array_en` is low only while idle with `pipe_stall` high and no cacheable miss present. A stalled miss keeps it high.
- R4: A cacheable miss with a clean victim follows this sequence:
  - `cache_stall` rises in the request cycle;
  - `bus_fetch_req` is high from the next cycle until `bus_ack`;
  - in the acknowledge cycle, `data_fill_we` and `tag_set_valid` pulse while the stall is still high;
  - the controller is idle on the following cycle.
- R5: A cacheable miss with a dirty victim requests the demand-line fetch first. It raises `bus_wb_req` only after the fetch is acknowledged. It asserts no fill on the fetch acknowledge; the fill happens in the writeback acknowledge cycle.
- R6: `cache_stall` stays high in every cycle of a miss writeback, including its acknowledge cycle.
- R7: An uncacheable request raises `bus_word_req` and never `bus_fetch_req`. It causes no array write. `cache_stall` stays high until the cycle in which `bus_ack` arrives, and is low in that cycle.
- R8: If `pipe_stall` is high when an uncacheable access is acknowledged, `rd_hold_sel` is high with `cache_stall` low from the next cycle. This lasts until the cycle after `pipe_stall` falls.
- R9: While idle, `trap_flush` suppresses `cpu_wr_en` and `tag_set_dirty`, and keeps the controller from starting any bus sequence. `cache_stall` still follows the request in that cycle.
- R10: An invalidate command stalls in its request cycle. On the next cycle `inval_all` and `array_en` are high for exactly one cycle, after which the controller is idle.
- R11: A flush walks every set for way 0, then every set for way 1, and so on. The line index is {`flush_way`, `flush_set`} and rises by one at a time. A clean line takes one cycle; a dirty line takes one cycle plus one per writeback request cycle. `flush_done` pulses once, on the last line, and the counters then read zero.
- R12: For a dirty line during a flush, `tag_clr_dirty` and `bus_wb_req` rise together. The flush address does not change until after `bus_ack`.
- R13: A cycle never combines all three of: returning data to the CPU, writing the data array, and starting a new bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_op | input | 2 | CPU request: 1 read, 2 write, else none |
| req_uncached | input | 1 | Request targets uncacheable space |
| pipe_stall | input | 1 | Pipeline is stalled by another source |
| trap_flush | input | 1 | Late pipeline flush for the current access |
| tag_hit | input | 1 | Tag lookup hit |
| victim_dirty | input | 1 | Victim line (or line at flush address) is dirty |
| flush_cmd | input | 1 | Start a whole-cache flush |
| inval_cmd | input | 1 | Invalidate the whole cache |
| bus_ack | input | 1 | Bus finished the current request |
| cache_stall | output | 1 | Cache holds the pipeline |
| array_en | output | 1 | Enable for tag and data arrays |
| cpu_wr_en | output | 1 | Write store data into the data array |
| data_fill_we | output | 1 | Write fetched line into the data array |
| tag_set_valid | output | 1 | Mark the filled line valid and clean |
| tag_set_dirty | output | 1 | Mark the hit line dirty |
| tag_clr_dirty | output | 1 | Clear dirty bit of the line at the flush address |
| inval_all | output | 1 | Clear all valid bits |
| bus_fetch_req | output | 1 | Request a line fetch |
| bus_wb_req | output | 1 | Request a line writeback |
| bus_word_req | output | 1 | Request a single-word uncacheable access |
| rd_hold_sel | output | 1 | Select held read data |
| flush_addr_sel | output | 1 | Address arrays with the flush counters |
| flush_set | output | SET_BITS | Flush set counter |
| flush_way | output | WAY_BITS | Flush way counter |
| flush_done | output | 1 | Flush finished (one-cycle pulse) |

## Verification
The flush is exercised with every one of the 256 dirty patterns of an 8-line cache. Each pattern yields an arithmetic expectation for:
- the cycle count;
- the number of dirty clears;
- the order of visits.

This separates a wrong visit order, a lost or extra writeback, a counter that moves before the acknowledge, and a wrong clean-line cost.

Single-access patterns cover the remaining cases:
- read and write hits, with and without stall and trap;
- misses with clean and with dirty victims;
- uncacheable accesses ending with and without a pipeline stall;
- invalidate.

These show apart fetch-then-evict ordering, fill timing, the stalled-hit enable rule and read-hold entry and exit.

// File: rtl/wbc_pkg.sv
// Shared types for the write-back cache control sequencer.
// Assumes: one-hot state encoding; request codes 1 = read, 2 = write.
package wbc_pkg;

    typedef enum logic [7:0] {
        ST_READY      = 8'b0000_0001,
        ST_FETCH      = 8'b0000_0010,
        ST_WRITEBACK  = 8'b0000_0100,
        ST_READ_HOLD  = 8'b0000_1000,
        ST_FLUSH_CHK  = 8'b0001_0000,
        ST_FLUSH_WB   = 8'b0010_0000,
        ST_FLUSH_INCR = 8'b0100_0000,
        ST_INVAL      = 8'b1000_0000
    } wbc_state_e;

    localparam logic [1:0] OP_READ  = 2'd1;
    localparam logic [1:0] OP_WRITE = 2'd2;

endpackage

// File: rtl/wbc_flush_walker.sv
// Flush address walker: one line counter, with the set in the low bits and
// the way in the high bits, so all sets of a way are visited before the next way.
// Assumes: the set and way counts are powers of two; the counter wraps to zero after the last line.
module wbc_flush_walker #(
    parameter int SET_BITS = 2,
    parameter int WAY_BITS = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                advance,
    output logic [SET_BITS-1:0] set_idx,
    output logic [WAY_BITS-1:0] way_idx,
    output logic                last_line
);
    localparam int LINE_BITS = SET_BITS + WAY_BITS;

    logic [LINE_BITS-1:0] line_q;

    // Purpose: step the line counter when the controller finishes a line.
    always_ff @(posedge clk) begin
        if (!rst_n)       line_q <= '0;
        else if (advance) line_q <= line_q + 1'b1;
    end

    assign set_idx   = line_q[SET_BITS-1:0];
    assign way_idx   = line_q[LINE_BITS-1:SET_BITS];
    assign last_line = &line_q;

    AST_WALK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (line_q == $past(line_q) + 1'b1)) else $error("walk step"); // R11
endmodule

// File: rtl/wbc_miss_track.sv
// Miss context register: records, when a miss sequence starts, whether the
// access is uncacheable and whether the victim must be evicted.
// Assumes: victim_dirty is valid in the cycle the miss sequence starts.
module wbc_miss_track (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic uncached_in,
    input  logic dirty_in,
    output logic uncached_q,
    output logic evict_q
);
    // Purpose: capture the access kind and the eviction need when a miss begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uncached_q <= 1'b0;
            evict_q    <= 1'b0;
        end else if (start) begin
            uncached_q <= uncached_in;
            evict_q    <= dirty_in & ~uncached_in;
        end
    end

    AST_NO_EVICT_UNCACHED: assert property (@(posedge clk) disable iff (!rst_n)
        !(uncached_q && evict_q)) else $error("uncached evict"); // R7
endmodule

// File: rtl/wbc_ctrl.sv
// Controller state register and decode: next state plus all Mealy and Moore
// control outputs. trap_flush holds the idle state and gates array writes
// there, but leaves the stall output alone.
// Assumes: the bus never acknowledges in the first cycle of a request.
module wbc_ctrl
    import wbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req_op,
    input  logic       req_uncached,
    input  logic       pipe_stall,
    input  logic       trap_flush,
    input  logic       tag_hit,
    input  logic       victim_dirty,
    input  logic       flush_cmd,
    input  logic       inval_cmd,
    input  logic       bus_ack,
    input  logic       unc_q,
    input  logic       evict_q,
    input  logic       walk_last,
    output logic       miss_start,
    output logic       walk_adv,
    output logic       cache_stall,
    output logic       array_en,
    output logic       cpu_wr_en,
    output logic       data_fill_we,
    output logic       tag_set_valid,
    output logic       tag_set_dirty,
    output logic       tag_clr_dirty,
    output logic       inval_all,
    output logic       bus_fetch_req,
    output logic       bus_wb_req,
    output logic       bus_word_req,
    output logic       rd_hold_sel,
    output logic       flush_addr_sel,
    output logic       flush_done
);
    wbc_state_e st_q, st_d;
    logic req_valid, req_write, cached_miss;

    assign req_valid   = (req_op == OP_READ) || (req_op == OP_WRITE);
    assign req_write   = (req_op == OP_WRITE);
    assign cached_miss = req_valid && !req_uncached && !tag_hit;

    // Purpose: hold the controller state.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_READY;
        else        st_q <= st_d;
    end

    // Purpose: decode next state and control outputs from state and inputs.
    always_comb begin
        st_d           = st_q;
        miss_start     = 1'b0;
        walk_adv       = 1'b0;
        cache_stall    = 1'b0;
        array_en       = 1'b1;
        cpu_wr_en      = 1'b0;
        data_fill_we   = 1'b0;
        tag_set_valid  = 1'b0;
        tag_set_dirty  = 1'b0;
        tag_clr_dirty  = 1'b0;
        inval_all      = 1'b0;
        bus_fetch_req  = 1'b0;
        bus_wb_req     = 1'b0;
        bus_word_req   = 1'b0;
        rd_hold_sel    = 1'b0;
        flush_addr_sel = 1'b0;
        flush_done     = 1'b0;
        unique case (st_q)
            ST_READY: begin
                array_en = !(pipe_stall && !cached_miss);
                if (flush_cmd) begin
                    cache_stall = 1'b1;
                    if (!trap_flush) st_d = ST_FLUSH_CHK;
                end else if (inval_cmd) begin
                    cache_stall = 1'b1;
                    if (!trap_flush) st_d = ST_INVAL;
                end else if (req_valid && (req_uncached || !tag_hit)) begin
                    cache_stall = 1'b1;
                    if (!trap_flush) begin
                        miss_start = 1'b1;
                        st_d       = ST_FETCH;
                    end
                end else if (req_valid && req_write && !pipe_stall && !trap_flush) begin
                    cpu_wr_en     = 1'b1;
                    tag_set_dirty = 1'b1;
                end
            end
            ST_FETCH: begin
                cache_stall   = 1'b1;
                bus_word_req  = unc_q;
                bus_fetch_req = !unc_q;
                if (bus_ack) begin
                    if (unc_q) begin
                        cache_stall = 1'b0;
                        st_d = pipe_stall ? ST_READ_HOLD : ST_READY;
                    end else if (evict_q) begin
                        st_d = ST_WRITEBACK;
                    end else begin
                        data_fill_we  = 1'b1;
                        tag_set_valid = 1'b1;
                        st_d          = ST_READY;
                    end
                end
            end
            ST_WRITEBACK: begin
                cache_stall = 1'b1;
                bus_wb_req  = 1'b1;
                if (bus_ack) begin
                    data_fill_we  = 1'b1;
                    tag_set_valid = 1'b1;
                    st_d          = ST_READY;
                end
            end
            ST_READ_HOLD: begin
                rd_hold_sel = 1'b1;
                if (!pipe_stall) st_d = ST_READY;
            end
            ST_FLUSH_CHK: begin
                cache_stall    = 1'b1;
                flush_addr_sel = 1'b1;
                if (victim_dirty) begin
                    bus_wb_req    = 1'b1;
                    tag_clr_dirty = 1'b1;
                    st_d          = ST_FLUSH_WB;
                end else begin
                    walk_adv = 1'b1;
                    if (walk_last) begin
                        flush_done = 1'b1;
                        st_d       = ST_READY;
                    end
                end
            end
            ST_FLUSH_WB: begin
                cache_stall    = 1'b1;
                flush_addr_sel = 1'b1;
                bus_wb_req     = 1'b1;
                if (bus_ack) st_d = ST_FLUSH_INCR;
            end
            ST_FLUSH_INCR: begin
                cache_stall    = 1'b1;
                flush_addr_sel = 1'b1;
                walk_adv       = 1'b1;
                if (walk_last) begin
                    flush_done = 1'b1;
                    st_d       = ST_READY;
                end else begin
                    st_d = ST_FLUSH_CHK;
                end
            end
            ST_INVAL: begin
                cache_stall = 1'b1;
                inval_all   = 1'b1;
                st_d        = ST_READY;
            end
            default: st_d = ST_READY;
        endcase
    end

    AST_WB_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WRITEBACK) |-> cache_stall) else $error("wb stall"); // R6
    AST_FETCH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WRITEBACK && $past(st_q) != ST_WRITEBACK) |-> ($past(st_q) == ST_FETCH && $past(bus_ack))) else $error("evict order"); // R5
    AST_TRAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_READY && trap_flush) |=> (st_q == ST_READY)) else $error("trap"); // R9
    AST_INVAL_EN: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all |-> array_en) else $error("inval enable"); // R10
    AST_WRITE_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_en || data_fill_we) |-> array_en) else $error("write enable"); // R3
endmodule

// File: rtl/wbc_fsm.sv
// Top of the write-back cache control sequencer: ties the controller, the
// miss context register and the flush walker together.
// Assumes: arrays, replacement and bus engine are external; victim_dirty
// reports the line at the flush address while flush_addr_sel is high.
module wbc_fsm #(
    parameter int SET_BITS = 2,
    parameter int WAY_BITS = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          req_op,
    input  logic                req_uncached,
    input  logic                pipe_stall,
    input  logic                trap_flush,
    input  logic                tag_hit,
    input  logic                victim_dirty,
    input  logic                flush_cmd,
    input  logic                inval_cmd,
    input  logic                bus_ack,
    output logic                cache_stall,
    output logic                array_en,
    output logic                cpu_wr_en,
    output logic                data_fill_we,
    output logic                tag_set_valid,
    output logic                tag_set_dirty,
    output logic                tag_clr_dirty,
    output logic                inval_all,
    output logic                bus_fetch_req,
    output logic                bus_wb_req,
    output logic                bus_word_req,
    output logic                rd_hold_sel,
    output logic                flush_addr_sel,
    output logic [SET_BITS-1:0] flush_set,
    output logic [WAY_BITS-1:0] flush_way,
    output logic                flush_done
);
    logic miss_start, walk_adv, walk_last, unc_q, evict_q;

    wbc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_uncached(req_uncached),
        .pipe_stall(pipe_stall), .trap_flush(trap_flush), .tag_hit(tag_hit),
        .victim_dirty(victim_dirty), .flush_cmd(flush_cmd), .inval_cmd(inval_cmd),
        .bus_ack(bus_ack), .unc_q(unc_q), .evict_q(evict_q), .walk_last(walk_last),
        .miss_start(miss_start), .walk_adv(walk_adv), .cache_stall(cache_stall),
        .array_en(array_en), .cpu_wr_en(cpu_wr_en), .data_fill_we(data_fill_we),
        .tag_set_valid(tag_set_valid), .tag_set_dirty(tag_set_dirty),
        .tag_clr_dirty(tag_clr_dirty), .inval_all(inval_all),
        .bus_fetch_req(bus_fetch_req), .bus_wb_req(bus_wb_req),
        .bus_word_req(bus_word_req), .rd_hold_sel(rd_hold_sel),
        .flush_addr_sel(flush_addr_sel), .flush_done(flush_done)
    );

    wbc_miss_track u_miss (
        .clk(clk), .rst_n(rst_n), .start(miss_start), .uncached_in(req_uncached),
        .dirty_in(victim_dirty), .uncached_q(unc_q), .evict_q(evict_q)
    );

    wbc_flush_walker #(.SET_BITS(SET_BITS), .WAY_BITS(WAY_BITS)) u_walk (
        .clk(clk), .rst_n(rst_n), .advance(walk_adv),
        .set_idx(flush_set), .way_idx(flush_way), .last_line(walk_last)
    );

    logic any_bus_req, cpu_return;
    assign any_bus_req = bus_fetch_req | bus_wb_req | bus_word_req;
    assign cpu_return  = (req_op == 2'd1 || req_op == 2'd2) && !cache_stall;

    AST_NO_TRIPLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_return && data_fill_we && any_bus_req && !$past(any_bus_req))) else $error("triple"); // R13
    AST_CLR_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        tag_clr_dirty |=> ($stable(flush_set) && $stable(flush_way))) else $error("clr addr"); // R12
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> !flush_done) else $error("done pulse"); // R11
    AST_UNCACHED_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_word_req |-> !(data_fill_we || cpu_wr_en)) else $error("uncached fill"); // R7
endmodule

// File: tb/wbc_fsm_test.sv
`timescale 1ns/100ps
module wbc_fsm_test;
    localparam int K = 3;  // writeback request cycles until acknowledge

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic req_uncached = 1'b0, pipe_stall = 1'b0, trap_flush = 1'b0, tag_hit = 1'b0;
    logic tb_dirty = 1'b0, flush_cmd = 1'b0, inval_cmd = 1'b0, bus_ack = 1'b0;
    logic flush_mode = 1'b0;
    logic [7:0] dmap = 8'd0;
    logic victim_dirty;
    logic cache_stall, array_en, cpu_wr_en, data_fill_we, tag_set_valid, tag_set_dirty;
    logic tag_clr_dirty, inval_all, bus_fetch_req, bus_wb_req, bus_word_req;
    logic rd_hold_sel, flush_addr_sel, flush_done;
    logic [1:0] flush_set;
    logic [0:0] flush_way;

    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    // stub dirty bits of the tag array during a flush
    assign victim_dirty = flush_mode ? dmap[{flush_way, flush_set}] : tb_dirty;

    wbc_fsm #(.SET_BITS(2), .WAY_BITS(1)) uut (
        .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_uncached(req_uncached),
        .pipe_stall(pipe_stall), .trap_flush(trap_flush), .tag_hit(tag_hit),
        .victim_dirty(victim_dirty), .flush_cmd(flush_cmd), .inval_cmd(inval_cmd),
        .bus_ack(bus_ack), .cache_stall(cache_stall), .array_en(array_en),
        .cpu_wr_en(cpu_wr_en), .data_fill_we(data_fill_we), .tag_set_valid(tag_set_valid),
        .tag_set_dirty(tag_set_dirty), .tag_clr_dirty(tag_clr_dirty), .inval_all(inval_all),
        .bus_fetch_req(bus_fetch_req), .bus_wb_req(bus_wb_req), .bus_word_req(bus_word_req),
        .rd_hold_sel(rd_hold_sel), .flush_addr_sel(flush_addr_sel),
        .flush_set(flush_set), .flush_way(flush_way), .flush_done(flush_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    // advance to the next falling edge, then let drives settle
    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        req_op = 2'd0; req_uncached = 0; pipe_stall = 0; trap_flush = 0;
        tag_hit = 0; tb_dirty = 0; flush_cmd = 0; inval_cmd = 0; bus_ack = 0;
    endtask

    initial begin
        #500000;
        checks++; fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step(); #1;
        // R1 reset state
        eq("R1 stall", cache_stall, 0);
        eq("R1 array_en", array_en, 1);
        eq("R1 bus", bus_fetch_req | bus_wb_req | bus_word_req, 0);
        eq("R1 counters", {flush_way, flush_set}, 0);

        // R2 read hit and write hit
        req_op = 2'd1; tag_hit = 1; #1;
        eq("R2 read hit stall", cache_stall, 0);
        req_op = 2'd2; #1;
        eq("R2 write hit wr", {cpu_wr_en, tag_set_dirty}, 3);
        eq("R2 write hit stall", cache_stall, 0);
        // R9 trap suppresses the write
        trap_flush = 1; #1;
        eq("R9 trap write", {cpu_wr_en, tag_set_dirty}, 0);
        // R3 stalled hit
        trap_flush = 0; req_op = 2'd1; pipe_stall = 1; #1;
        eq("R3 stalled hit en", array_en, 0);
        tag_hit = 0; trap_flush = 1; #1;
        eq("R3 stalled miss en", array_en, 1);
        eq("R9 trap stall kept", cache_stall, 1);
        step(); idle_inputs(); #1;
        eq("R9 no bus after trap", bus_fetch_req | bus_word_req, 0);
        eq("R9 idle after trap", cache_stall, 0);

        // R4 clean miss
        req_op = 2'd1; tag_hit = 0; tb_dirty = 0; #1;
        eq("R4 stall on miss", cache_stall, 1);
        eq("R4 no fetch yet", bus_fetch_req, 0);
        step(); #1;
        eq("R4 fetch req", bus_fetch_req, 1);
        eq("R4 no wb", bus_wb_req, 0);
        step(); bus_ack = 1; #1;
        eq("R4 fill", {data_fill_we, tag_set_valid}, 3);
        eq("R4 stall in fill", cache_stall, 1);
        eq("R13 no return in fill", (cache_stall == 0) ? 1 : 0, 0);
        step(); bus_ack = 0; tag_hit = 1; #1;
        eq("R4 back to idle", cache_stall, 0);
        eq("R4 bus idle", bus_fetch_req, 0);

        // R5/R6 dirty miss
        tag_hit = 0; tb_dirty = 1; #1;
        step(); tb_dirty = 0; #1;
        eq("R5 fetch first", {bus_fetch_req, bus_wb_req}, 2);
        step(); bus_ack = 1; #1;
        eq("R5 no fill on fetch ack", data_fill_we, 0);
        step(); bus_ack = 0; #1;
        eq("R5 writeback second", {bus_fetch_req, bus_wb_req}, 1);
        eq("R6 stall wb1", cache_stall, 1);
        pipe_stall = 0;
        step(); #1;
        eq("R6 stall wb2", cache_stall, 1);
        step(); bus_ack = 1; #1;
        eq("R5 fill on wb ack", {data_fill_we, tag_set_valid}, 3);
        eq("R6 stall at ack", cache_stall, 1);
        step(); bus_ack = 0; tag_hit = 1; #1;
        eq("R5 idle after", cache_stall | bus_wb_req, 0);

        // R7/R8 uncached with stall at ack
        req_uncached = 1; tag_hit = 0; #1;
        eq("R7 stall", cache_stall, 1);
        step(); #1;
        eq("R7 word req", {bus_word_req, bus_fetch_req}, 2);
        eq("R7 stall before ack", cache_stall, 1);
        step(); bus_ack = 1; pipe_stall = 1; #1;
        eq("R7 stall drops at ack", cache_stall, 0);
        eq("R7 no fill", data_fill_we | cpu_wr_en, 0);
        step(); bus_ack = 0; #1;
        eq("R8 hold", {rd_hold_sel, cache_stall}, 2);
        step(); pipe_stall = 0; #1;
        eq("R8 hold until release", rd_hold_sel, 1);
        step(); req_op = 2'd0; req_uncached = 0; #1;
        eq("R8 hold released", rd_hold_sel, 0);

        // R7 uncached without stall: straight back to idle
        req_op = 2'd2; req_uncached = 1; #1;
        step(); step(); bus_ack = 1; #1;
        eq("R7 ack no stall", cache_stall, 0);
        step(); idle_inputs(); #1;
        eq("R7 no hold", rd_hold_sel | bus_word_req, 0);

        // R10 invalidate
        inval_cmd = 1; #1;
        eq("R10 stall", cache_stall, 1);
        step(); inval_cmd = 0; #1;
        eq("R10 inval", {inval_all, array_en, cache_stall}, 7);
        step(); #1;
        eq("R10 one cycle", {inval_all, cache_stall}, 0);

        // R11/R12 exhaustive flush sweep over every dirty pattern
        flush_mode = 1;
        for (int p = 0; p < 256; p++) begin
            int cyc, clr, wbcnt, d, prev, clr_idx, bad_order, bad_ack, bad_clr;
            bit done;
            dmap = p[7:0];
            d = $countones(dmap);
            cyc = 0; clr = 0; wbcnt = 0; prev = 0; clr_idx = -1;
            bad_order = 0; bad_ack = 0; bad_clr = 0; done = 0;
            flush_cmd = 1; #1;
            if (p == 0) eq("R11 flush stall", cache_stall, 1);
            while (!done && cyc < 200) begin
                int idx;
                step(); flush_cmd = 0; #1;
                cyc++;
                idx = {flush_way, flush_set};
                if (idx != prev && idx != prev + 1) bad_order++;
                prev = idx;
                if (bus_wb_req) wbcnt++; else wbcnt = 0;
                bus_ack = bus_wb_req && (wbcnt == K);
                #1;
                if (tag_clr_dirty) begin
                    clr++;
                    clr_idx = idx;
                    if (!dmap[idx] || !bus_wb_req || wbcnt != 1) bad_clr++;
                end
                if (bus_ack && idx != clr_idx) bad_ack++;
                if (flush_done) begin
                    done = 1;
                    if (idx != 7) bad_order++;
                end
            end
            eq("R11 flush cycles", cyc, 8 + d * K);
            eq("R11 visit order", bad_order, 0);
            eq("R12 clear count", clr, d);
            eq("R12 clear with wb start", bad_clr, 0);
            eq("R12 address held to ack", bad_ack, 0);
            step(); bus_ack = 0; #1;
            eq("R11 done single", {flush_done, cache_stall}, 0);
            eq("R11 counters wrap", {flush_way, flush_set}, 0);
        end
        flush_mode = 0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule